// File: doc/BRIEF.md
# SMBus Indexed Register Bank Slave

This block is an SMBus slave that runs on a fast system clock and treats the bus lines as ordinary sampled inputs. SCL and SDA each pass through a two-flop synchronizer. START, repeated START and STOP are found by watching SDA change while SCL is high. Bytes move in on SCL rising edges and out after SCL falling edges. The slave drives the acknowledge bit itself. The block holds a bank of 64 byte-wide configuration registers. The rest of the chip sees their contents on a flat output vector. One register shows an external status byte, such as latched straps or alarm flags.

A master reaches the bank in three ways. An indexed block write sends an offset, a byte count and then that many data bytes. An indexed block read sends an offset, then a repeated START and the read address. The slave answers with a programmable count byte and then data from the offset upward. Setting the top bit of the offset selects single-byte mode, in which the low offset bits address one register and exactly one byte moves.

Top module: `smb_reg_slave`

## Requirements
- R1: The slave acknowledges the 7-bit address 69h (write byte D2h, read byte D3h). For any other address it leaves SDA released and ignores the bus until the next START.
- R2: In a block write (offset byte bit 7 = 0), the byte after the offset is a count N. The next N data bytes are each acknowledged and stored at consecutive registers starting at offset[5:0].
- R3: A count of zero is acknowledged and stores nothing. Data bytes beyond the count are not acknowledged and not stored.
- R4: In a block read (offset write, repeated START, D3h), the first byte returned is the content of register 8. Data from offset[5:0] upward follows.
- R5: A master not-acknowledge ends the read: SDA is released and stays released until a new START. This also holds when the read stops before the count is reached.
- R6: With offset bit 7 = 1, offset[5:0] addresses one register. A write stores exactly one byte and does not acknowledge a second. A read returns that register's content directly, with no count byte.
- R7: Register 8 resets to 14h and is writable.
- R8: Register 7 reads 05h, register 62 reads 60h and register 63 reads 13h. Register 21 reads the status input. Writes to these four are ignored.
- R9: The register pointer wraps from 63 to 0 during block writes and block reads.
- R10: The slave changes its SDA drive only right after a detected SCL falling edge, START or STOP.
- R11: After reset SDA is released, every writable register other than 8 holds 00h, and the output vector shows all register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| status_i | input | 8 | Read-only status byte shown at register 21 |
| regs_o | output | 512 | Register contents, register k at bits [8k+7:8k] |

## Verification
A corrupted pointer or byte count shows up within one transaction. It appears as a wrong data byte on a block read, or as a wrong acknowledge on the first byte past the count. A stuck transfer state would leave SDA held low after a master not-acknowledge or STOP, which is visible at sda_oe_o on the next system clock. Filtering mistakes on read-only registers appear on regs_o one clock after the write strobe. They are checked across the whole bank after every transaction.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} link_st_e;
  typedef enum logic [1:0] {PH_ADDR, PH_OFFSET, PH_COUNT, PH_DATA} rx_ph_e;

  localparam int          ID_ADDR  = 7;
  localparam logic [7:0]  ID_VAL   = 8'h05;
  localparam logic [7:0]  CNT_RST  = 8'h14;
  localparam logic [7:0]  TOP1_VAL = 8'h60;  // second-to-last register
  localparam logic [7:0]  TOP0_VAL = 8'h13;  // last register
endpackage

// File: rtl/smb_sync_det.sv
module smb_sync_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile import smb_pkg::*; #(
  parameter int NUM_REGS = 64,
  parameter int CNT_ADDR = 8,
  parameter int STS_ADDR = 21,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [7:0]            wdata_i,
  input  logic [AW-1:0]         raddr_i,
  output logic [7:0]            rdata_o,
  input  logic [7:0]            status_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] view [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == ID_ADDR) begin : g_id
      assign view[i] = ID_VAL;
    end else if (i == NUM_REGS-2) begin : g_top1
      assign view[i] = TOP1_VAL;
    end else if (i == NUM_REGS-1) begin : g_top0
      assign view[i] = TOP0_VAL;
    end else if (i == STS_ADDR) begin : g_sts
      assign view[i] = status_i;
    end else begin : g_rw
      localparam logic [7:0] RST = (i == CNT_ADDR) ? CNT_RST : 8'h00;
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          q <= RST;
        else if (we_i && waddr_i == AW'(i))   q <= wdata_i;
      end
      assign view[i] = q;
    end
    assign regs_o[i*8 +: 8] = view[i];
  end

  assign rdata_o = view[raddr_i];
endmodule

// File: rtl/smb_link.sv
module smb_link import smb_pkg::*; #(
  parameter int         AW       = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic [AW-1:0] raddr_o,
  input  logic [7:0]    rdata_i,
  input  logic [7:0]    cnt_i
);
  link_st_e      st;
  rx_ph_e        ph;
  logic [3:0]    bit_cnt;
  logic [7:0]    sh, remain;
  logic [AW-1:0] ptr;
  logic          single, rd_mode, m_ack, drive;
  logic          byte_end;

  assign byte_end = (st == ST_RX) && scl_fall_i && (bit_cnt == 4'd8);
  assign we_o     = byte_end && (ph == PH_DATA) && (remain != 8'd0);
  assign waddr_o  = ptr;
  assign wdata_o  = sh;
  assign raddr_o  = ptr;
  assign sda_oe_o = drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; ph <= PH_ADDR; bit_cnt <= '0; sh <= '0; remain <= '0;
      ptr <= '0; single <= 1'b0; rd_mode <= 1'b0; m_ack <= 1'b0; drive <= 1'b0;
    end else if (start_i) begin
      st <= ST_RX; ph <= PH_ADDR; bit_cnt <= '0; drive <= 1'b0;
    end else if (stop_i) begin
      st <= ST_IDLE; drive <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise_i && bit_cnt != 4'd8) begin
            sh      <= {sh[6:0], sda_i};
            bit_cnt <= bit_cnt + 4'd1;
          end
          if (byte_end) begin
            st <= ST_RX_ACK;
            unique case (ph)
              PH_ADDR: begin
                if (sh[7:1] == DEV_ADDR) begin
                  drive   <= 1'b1;
                  rd_mode <= sh[0];
                  ph      <= PH_OFFSET;
                  if (sh[0]) sh <= single ? rdata_i : cnt_i;
                end else begin
                  st <= ST_IDLE;
                end
              end
              PH_OFFSET: begin
                drive  <= 1'b1;
                ptr    <= sh[AW-1:0];
                single <= sh[7];
                remain <= 8'd1;
                ph     <= sh[7] ? PH_DATA : PH_COUNT;
              end
              PH_COUNT: begin
                drive  <= 1'b1;
                remain <= sh;
                ph     <= PH_DATA;
              end
              PH_DATA: begin
                if (remain != 8'd0) begin
                  drive  <= 1'b1;
                  ptr    <= ptr + AW'(1);
                  remain <= remain - 8'd1;
                end
              end
              default: ;
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              st    <= ST_TX;
              drive <= ~sh[7];
            end else begin
              st    <= ST_RX;
              drive <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise_i) bit_cnt <= bit_cnt + 4'd1;
          if (scl_fall_i) begin
            if (bit_cnt == 4'd8) begin
              drive <= 1'b0;
              st    <= ST_TX_ACK;
            end else if (bit_cnt != 4'd0) begin
              sh    <= {sh[6:0], 1'b0};
              drive <= ~sh[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) m_ack <= ~sda_i;
          if (scl_fall_i) begin
            if (m_ack && !single) begin
              sh      <= rdata_i;
              ptr     <= ptr + AW'(1);
              drive   <= ~rdata_i[7];
              bit_cnt <= '0;
              st      <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave import smb_pkg::*; #(
  parameter int         NUM_REGS = 64,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         CNT_ADDR = 8,
  parameter int         STS_ADDR = 21
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  input  logic [7:0]            status_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int AW = $clog2(NUM_REGS);

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  smb_sync_det #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_link #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .sda_i(sda_s),
    .sda_oe_o,
    .we_o(wr_en), .waddr_o(wr_addr), .wdata_o(wr_data),
    .raddr_o(rd_addr), .rdata_i(rd_data),
    .cnt_i(regs_o[CNT_ADDR*8 +: 8])
  );

  smb_regfile #(.NUM_REGS(NUM_REGS), .CNT_ADDR(CNT_ADDR), .STS_ADDR(STS_ADDR)) u_regs (
    .clk_i, .rst_ni,
    .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data),
    .raddr_i(rd_addr), .rdata_o(rd_data),
    .status_i, .regs_o
  );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sda_oe_i,
  input logic scl_fall_i,
  input logic start_i,
  input logic stop_i,
  input logic we_i
);
  assert_oe_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_i) |-> $past(scl_fall_i));

  assert_oe_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_i) |-> $past(scl_fall_i || start_i || stop_i));

  assert_stop_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  assert_start_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

  assert_write_acked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> sda_oe_i);
endmodule

bind smb_reg_slave smb_reg_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sda_oe_i(sda_oe_o),
  .scl_fall_i(scl_fall), .start_i(start_det), .stop_i(stop_det), .we_i(wr_en)
);

// File: tb/smb_reg_slave_bench.sv
module smb_reg_slave_bench;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic [7:0] status = 8'h5a;
  logic [511:0] regs;
  assign sda_bus = sda_m & ~sda_oe;

  smb_reg_slave u_smb_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .status_i(status), .regs_o(regs)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] shadow [64];
  logic [7:0] buf_d [16];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input int a);
    case (a)
      7:       return 8'h05;
      62:      return 8'h60;
      63:      return 8'h13;
      21:      return status;
      default: return shadow[a];
    endcase
  endfunction

  function automatic void model_wr(input int a, input logic [7:0] d);
    if (a != 7 && a != 62 && a != 63 && a != 21) shadow[a] = d;
  endfunction

  task automatic qw(input int n = 1);
    repeat (n*Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); ack = ~sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1'b1; qw(); b[i] = sda_bus; qw(); scl_m = 1'b0; qw();
    end
    sda_m = ~ack; qw(); scl_m = 1'b1; qw(2); scl_m = 1'b0; qw(); sda_m = 1'b1;
  endtask

  task automatic cmp_all(input string tag);
    for (int i = 0; i < 64; i++) check(tag, regs[i*8 +: 8], model_rd(i));
  endtask

  // block write: count byte cnt, nb data bytes sent from buf_d
  task automatic wr_block(input logic [7:0] off, input logic [7:0] cnt, input int nb, input string tag);
    bit a;
    bus_start();
    send_byte(8'hd2, a); check({tag, " R1 addr ack"}, a, 1);
    send_byte(off, a);   check({tag, " R2 offset ack"}, a, 1);
    send_byte(cnt, a);   check({tag, " R3 count ack"}, a, 1);
    for (int k = 0; k < nb; k++) begin
      send_byte(buf_d[k], a);
      check({tag, " R3 data ack"}, a, (k < cnt) ? 1 : 0);
      if (k < cnt) model_wr((off + k) % 64, buf_d[k]);
    end
    bus_stop();
    check({tag, " R5 released"}, sda_oe, 0);
    cmp_all({tag, " R2 bank"});
  endtask

  task automatic rd_block(input logic [7:0] off, input int nb, input string tag);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hd2, a); check({tag, " R1 addr ack"}, a, 1);
    send_byte(off, a);   check({tag, " R4 offset ack"}, a, 1);
    bus_start();
    send_byte(8'hd3, a); check({tag, " R1 read addr ack"}, a, 1);
    recv_byte(1'b1, b);  check({tag, " R4 count byte"}, b, shadow[8]);
    for (int k = 0; k < nb; k++) begin
      recv_byte(k < nb - 1, b);
      check({tag, " R4 data"}, b, model_rd((off + k) % 64));
    end
    check({tag, " R5 released after nack"}, sda_oe, 0);
    bus_stop();
  endtask

  task automatic wr_single(input int adr, input logic [7:0] d, input string tag);
    bit a;
    bus_start();
    send_byte(8'hd2, a);                   check({tag, " R1"}, a, 1);
    send_byte(8'h80 | 8'(adr), a);         check({tag, " R6 offset ack"}, a, 1);
    send_byte(d, a);                       check({tag, " R6 data ack"}, a, 1);
    model_wr(adr, d);
    send_byte(~d, a);                      check({tag, " R6 second byte nack"}, a, 0);
    bus_stop();
    cmp_all({tag, " R6 bank"});
  endtask

  task automatic rd_single(input int adr, input string tag);
    bit a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hd2, a);
    send_byte(8'h80 | 8'(adr), a);
    bus_start();
    send_byte(8'hd3, a);                   check({tag, " R1 read ack"}, a, 1);
    recv_byte(1'b0, b);                    check({tag, " R6 single read"}, b, model_rd(adr));
    bus_stop();
    check({tag, " R5 released"}, sda_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit a;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) shadow[i] = 8'h00;
    shadow[8] = 8'h14;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 / R7 / R8 reset view
    check("R11 sda released", sda_oe, 0);
    cmp_all("R11 R7 R8 reset");

    // R1 foreign address
    bus_start();
    send_byte(8'ha0, a); check("R1 foreign addr nack", a, 0);
    send_byte(8'h00, a); check("R1 foreign ignored", a, 0);
    bus_stop();
    check("R1 foreign released", sda_oe, 0);

    // R2 / R4 block write then read
    for (int k = 0; k < 4; k++) buf_d[k] = 8'(8'hc0 + k);
    wr_block(8'h10, 8'd4, 4, "blk");
    rd_block(8'h10, 4, "blk");

    // R7 count register programming
    buf_d[0] = 8'h03;
    wr_block(8'h08, 8'd1, 1, "R7 count");
    rd_block(8'h10, 3, "R7 count read");

    // R3 zero count and overrun
    buf_d[0] = 8'haa;
    wr_block(8'h20, 8'd0, 1, "R3 zero");
    buf_d[0] = 8'h11; buf_d[1] = 8'h22;
    wr_block(8'h21, 8'd1, 2, "R3 overrun");

    // R8 read-only and R9 wrap
    for (int k = 0; k < 4; k++) buf_d[k] = 8'(8'h71 + k);
    wr_block(8'h06, 8'd3, 3, "R8 ro id");
    wr_block(8'd62, 8'd4, 4, "R9 R8 wrap");
    rd_block(8'd62, 4, "R9 wrap read");
    buf_d[0] = 8'h99;
    wr_block(8'd21, 8'd1, 1, "R8 status");
    status = 8'h3c;
    rd_single(21, "R8 status");

    // R6 single-byte mode
    wr_single(37, 8'h6e, "R6 single");
    rd_single(37, "R6 single");

    // R5 early end of block read
    rd_block(8'h10, 2, "R5 early");

    // random block traffic
    for (int it = 0; it < 10; it++) begin
      logic [7:0] off;
      int n;
      off = 8'($urandom % 64);
      n   = 1 + ($urandom % 5);
      for (int k = 0; k < n; k++) buf_d[k] = 8'($urandom);
      if (off == 8'd7 || off == 8'd8) off = 8'd30; // keep count register small
      if (off + n > 8'd6 && off <= 8'd8) off = 8'd40;
      wr_block(off, 8'(n), n, "rand R2");
      status = 8'($urandom);
      rd_block(off, n, "rand R4");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule